// File: doc/BRIEF.md
# Integer ALU for a 32-bit load/store RISC core

This block is the purely combinational arithmetic and logic unit of a 32-bit integer execute stage. It takes two operand words, a 5-bit constant shift count and a 5-bit operation code. In the same cycle it returns a 32-bit result, a flag that is high when the result is all zeros, and a signed-overflow flag. The decoder upstream chooses the code, and the trap logic downstream reads the overflow flag.

The unit covers these operations:
- addition and subtraction, each in a trapping and a non-trapping form;
- the four bitwise functions;
- signed and unsigned less-than compares;
- the upper-immediate load;
- left, logical-right and arithmetic-right shifts, each by a constant count or by a count taken from a register.

For shifts, `opB` is the word that is shifted. A variable shift takes its count from `opA`. A branch on equality subtracts the two registers and then tests the zero flag.

Top module: `alu32`

## Requirements
- R1: Codes 0 (trapping add), 1 (non-trapping add), 2 (trapping subtract) and 3 (non-trapping subtract) return opA+opB or opA-opB modulo 2^32. Codes 0 and 1 add; codes 2 and 3 subtract.
- R2: Codes 0 and 2 raise `overflow` exactly when the true two's-complement sum or difference does not fit in 32 signed bits.
- R3: Every code other than 0 and 2 holds `overflow` low. This includes codes 1 and 3 when their operands overflow.
- R4: Codes 4, 5, 6 and 7 return the bitwise AND, OR, XOR and NOR of opA and opB, in that order.
- R5: Code 8 returns 1 when opA is less than opB as signed numbers, and 0 otherwise.
- R6: Code 9 returns 1 when opA is less than opB as unsigned numbers, and 0 otherwise.
- R7: Code 10 places opB[15:0] in result[31:16] and drives result[15:0] to zero.
- R8: Codes 11, 12 and 13 shift opB left, logically right and arithmetically right by `shamt`.
- R9: Codes 14, 15 and 16 shift opB left, logically right and arithmetically right by opA[4:0]. Bits opA[31:5] have no effect, and neither does `shamt`.
- R10: An arithmetic right shift fills the vacated upper bits with opB[31]. A logical right shift fills them with zeros.
- R11: `zero` is high exactly when the 32-bit result is all zeros, for every code.
- R12: Codes 17 to 31 return a zero result, with `zero` high and `overflow` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; supplies the count for variable shifts |
| opB | input | 32 | Second operand; the word that is shifted, and the source of the upper immediate |
| shamt | input | 5 | Constant shift count |
| opSel | input | 5 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the trapping add and subtract |

## Verification
The hardest conditions to reach are the carry and overflow boundaries of the shared subtractor. At these boundaries the signed compare must use the overflow term rather than the raw sign bit, and the non-trapping forms must stay silent. The stimulus therefore crosses every code with a fixed set of edge operands: zero, one, all ones, both signed extremes and their neighbours. It adds a register count whose upper bits are set while its low five bits are zero, which exposes any shifter that reads too many count bits. A seeded pseudo-random phase then covers ordinary operand mixes.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_LUI  = 5'd10,
    OP_SLL  = 5'd11,
    OP_SRL  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLLV = 5'd14,
    OP_SRLV = 5'd15,
    OP_SRAV = 5'd16
  } aluOp_e;

  // bitwise function select
  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOR = 2'd3
  } logicFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     selArith;
    logic     selLogic;
    logic     selSlt;
    logic     selLui;
    logic     selShift;
    logic     subtract;
    logic     trapEn;
    logic     sltUnsigned;
    logic     shRight;
    logic     shArith;
    logic     shVar;
    logicFn_e logicFn;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [4:0] opSel,
  output aluCtrl_t   ctl
);

  always_comb begin
    ctl = '0;
    case (opSel)
      OP_ADD:  begin ctl.selArith = 1'b1; ctl.trapEn = 1'b1; end
      OP_ADDU: begin ctl.selArith = 1'b1; end
      OP_SUB:  begin ctl.selArith = 1'b1; ctl.subtract = 1'b1; ctl.trapEn = 1'b1; end
      OP_SUBU: begin ctl.selArith = 1'b1; ctl.subtract = 1'b1; end
      OP_AND:  begin ctl.selLogic = 1'b1; ctl.logicFn = LF_AND; end
      OP_OR:   begin ctl.selLogic = 1'b1; ctl.logicFn = LF_OR;  end
      OP_XOR:  begin ctl.selLogic = 1'b1; ctl.logicFn = LF_XOR; end
      OP_NOR:  begin ctl.selLogic = 1'b1; ctl.logicFn = LF_NOR; end
      OP_SLT:  begin ctl.selSlt = 1'b1; ctl.subtract = 1'b1; end
      OP_SLTU: begin ctl.selSlt = 1'b1; ctl.subtract = 1'b1; ctl.sltUnsigned = 1'b1; end
      OP_LUI:  begin ctl.selLui = 1'b1; end
      OP_SLL:  begin ctl.selShift = 1'b1; end
      OP_SRL:  begin ctl.selShift = 1'b1; ctl.shRight = 1'b1; end
      OP_SRA:  begin ctl.selShift = 1'b1; ctl.shRight = 1'b1; ctl.shArith = 1'b1; end
      OP_SLLV: begin ctl.selShift = 1'b1; ctl.shVar = 1'b1; end
      OP_SRLV: begin ctl.selShift = 1'b1; ctl.shVar = 1'b1; ctl.shRight = 1'b1; end
      OP_SRAV: begin ctl.selShift = 1'b1; ctl.shVar = 1'b1; ctl.shRight = 1'b1; ctl.shArith = 1'b1; end
      default: ctl = '0;
    endcase
  end

  // At most one result unit is ever enabled; unused codes enable none.
  always_comb begin
    AST_UNIT_ONEHOT: assert ($onehot0({ctl.selArith, ctl.selLogic, ctl.selSlt,
                                       ctl.selLui, ctl.selShift})); // R12
  end

endmodule

// File: rtl/alu_dpath.sv
`timescale 1ns/1ps
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamt,
  input  aluCtrl_t         ctl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  // shared adder / subtractor
  logic [WIDTH-1:0] bOperand;
  logic [WIDTH:0]   sumExt;
  logic [WIDTH-1:0] sumWord;
  logic             carryOut;
  logic             signedOvf;
  logic             lessSigned;
  logic             lessUnsigned;

  assign bOperand     = ctl.subtract ? ~opB : opB;
  assign sumExt       = {1'b0, opA} + {1'b0, bOperand} + {{WIDTH{1'b0}}, ctl.subtract};
  assign sumWord      = sumExt[WIDTH-1:0];
  assign carryOut     = sumExt[WIDTH];
  assign signedOvf    = (opA[WIDTH-1] == bOperand[WIDTH-1]) && (sumWord[WIDTH-1] != opA[WIDTH-1]);
  assign lessSigned   = sumWord[WIDTH-1] ^ signedOvf;
  assign lessUnsigned = ~carryOut;

  // bitwise unit
  logic [WIDTH-1:0] logicWord;
  always_comb begin
    case (ctl.logicFn)
      LF_AND:  logicWord = opA & opB;
      LF_OR:   logicWord = opA | opB;
      LF_XOR:  logicWord = opA ^ opB;
      default: logicWord = ~(opA | opB);
    endcase
  end

  // barrel shifter: right-shift stages, left shift via bit reversal
  logic [SHW-1:0]   shCount;
  logic             shFill;
  logic [WIDTH-1:0] opBRev;
  logic [WIDTH-1:0] stageOut;
  logic [WIDTH-1:0] stageRev;
  logic [WIDTH-1:0] shiftWord;
  logic [WIDTH-1:0] stg [0:SHW];

  assign shCount = ctl.shVar ? opA[SHW-1:0] : shamt;
  assign shFill  = ctl.shRight & ctl.shArith & opB[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign opBRev[i]   = opB[WIDTH-1-i];
    assign stageRev[i] = stageOut[WIDTH-1-i];
  end

  assign stg[0] = ctl.shRight ? opB : opBRev;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stg[k+1] = shCount[k] ? {{(2**k){shFill}}, stg[k][WIDTH-1:(2**k)]} : stg[k];
  end

  assign stageOut  = stg[SHW];
  assign shiftWord = ctl.shRight ? stageOut : stageRev;

  // result selection
  logic [WIDTH-1:0] sltWord;
  logic [WIDTH-1:0] luiWord;

  assign sltWord = {{(WIDTH-1){1'b0}}, (ctl.sltUnsigned ? lessUnsigned : lessSigned)};
  assign luiWord = {opB[HALF-1:0], {HALF{1'b0}}};

  assign result = ({WIDTH{ctl.selArith}} & sumWord)
                | ({WIDTH{ctl.selLogic}} & logicWord)
                | ({WIDTH{ctl.selSlt}}   & sltWord)
                | ({WIDTH{ctl.selLui}}   & luiWord)
                | ({WIDTH{ctl.selShift}} & shiftWord);

  assign zero     = (result == '0);
  assign overflow = ctl.trapEn & ctl.selArith & signedOvf;

  always_comb begin
    if (ctl.selSlt) begin
      AST_SLT_BOOL: assert (result[WIDTH-1:1] == '0); // R5
    end
    if (ctl.selLui) begin
      AST_LUI_LOW: assert (result[HALF-1:0] == '0); // R7
    end
    if (ctl.selShift && ctl.shArith && opB[WIDTH-1]) begin
      AST_SRA_SIGN: assert (result[WIDTH-1]); // R10
    end
  end

endmodule

// File: rtl/alu32.sv
`timescale 1ns/1ps
module alu32
  import alu_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [4:0]  shamt,
  input  logic [4:0]  opSel,
  output logic [31:0] result,
  output logic        zero,
  output logic        overflow
);

  aluCtrl_t ctl;

  alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctl   (ctl)
  );

  alu_dpath #(.WIDTH(32)) u_dpath (
    .opA      (opA),
    .opB      (opB),
    .shamt    (shamt),
    .ctl      (ctl),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  always_comb begin
    if (opSel != OP_ADD && opSel != OP_SUB) begin
      AST_NO_OVERFLOW: assert (!overflow); // R3
    end
    if (opSel == OP_SUBU && opA == opB) begin
      AST_ZERO_FLAG: assert (zero); // R11
    end
  end

endmodule

// File: tb/alu32_tb_top.sv
`timescale 1ns/1ps
module alu32_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  shamt = '0;
  logic [4:0]  opSel = '0;
  logic [31:0] result;
  logic        zero;
  logic        overflow;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  alu32 dut_i (
    .opA      (opA),
    .opB      (opB),
    .shamt    (shamt),
    .opSel    (opSel),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  function automatic string reqTag(int op);
    case (op)
      0, 1, 2, 3:   return "R1";
      4, 5, 6, 7:   return "R4";
      8:            return "R5";
      9:            return "R6";
      10:           return "R7";
      11, 12:       return "R8";
      13:           return "R8/R10";
      14, 15:       return "R9";
      16:           return "R9/R10";
      default:      return "R12";
    endcase
  endfunction

  // model: returns {overflow, result}
  function automatic logic [32:0] model(int op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
    logic [31:0]        r;
    logic               v;
    logic signed [32:0] wide;
    r = '0;
    v = 1'b0;
    case (op)
      0: begin wide = $signed({a[31], a}) + $signed({b[31], b}); r = a + b; v = wide[32] != wide[31]; end
      1: r = a + b;
      2: begin wide = $signed({a[31], a}) - $signed({b[31], b}); r = a - b; v = wide[32] != wide[31]; end
      3: r = a - b;
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~(a | b);
      8: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      9: r = (a < b) ? 32'd1 : 32'd0;
      10: r = {b[15:0], 16'h0000};
      11: r = b << sh;
      12: r = b >> sh;
      13: r = 32'($signed(b) >>> sh);
      14: r = b << a[4:0];
      15: r = b >> a[4:0];
      16: r = 32'($signed(b) >>> a[4:0]);
      default: r = '0;
    endcase
    return {v, r};
  endfunction

  task automatic applyAndCheck(int op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
    logic [32:0] exp;
    @(posedge clk);
    opSel = 5'(op);
    opA   = a;
    opB   = b;
    shamt = sh;
    @(negedge clk);
    exp = model(op, a, b, sh);
    checkCnt++;
    if (result !== exp[31:0]) begin
      failCnt++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d result actual=%h expected=%h",
               reqTag(op), op, a, b, sh, result, exp[31:0]);
    end
    checkCnt++;
    if (zero !== (exp[31:0] == 32'd0)) begin
      failCnt++;
      $display("FAIL R11 op=%0d a=%h b=%h zero actual=%b expected=%b",
               op, a, b, zero, (exp[31:0] == 32'd0));
    end
    checkCnt++;
    if (overflow !== exp[32]) begin
      failCnt++;
      $display("FAIL %s op=%0d a=%h b=%h overflow actual=%b expected=%b",
               (op == 0 || op == 2) ? "R2" : "R3", op, a, b, overflow, exp[32]);
    end
  endtask

  logic [31:0] edgeVals [12];
  logic [4:0]  shVals [4];

  initial begin
    logic [31:0] lfsr;
    edgeVals[0]  = 32'h0000_0000;
    edgeVals[1]  = 32'h0000_0001;
    edgeVals[2]  = 32'h0000_0002;
    edgeVals[3]  = 32'h7FFF_FFFF;
    edgeVals[4]  = 32'h8000_0000;
    edgeVals[5]  = 32'hFFFF_FFFF;
    edgeVals[6]  = 32'hFFFF_FFFE;
    edgeVals[7]  = 32'h8000_0001;
    edgeVals[8]  = 32'h0000_FFFF;
    edgeVals[9]  = 32'h1234_5678;
    edgeVals[10] = 32'h0000_001F;
    edgeVals[11] = 32'h0000_0120; // upper count bits set, low five zero (R9)
    shVals[0] = 5'd0;
    shVals[1] = 5'd1;
    shVals[2] = 5'd15;
    shVals[3] = 5'd31;

    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle state: code 0 on zero operands gives a zero result, zero high
    @(negedge clk);
    checkCnt++;
    if (result !== 32'd0 || zero !== 1'b1 || overflow !== 1'b0) begin
      failCnt++;
      $display("FAIL R11 idle result=%h zero=%b ovf=%b expected=00000000 1 0",
               result, zero, overflow);
    end

    // sweep every code across edge operands and shift counts
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int s = 0; s < 4; s++)
            applyAndCheck(op, edgeVals[i], edgeVals[j], shVals[s]);

    // pseudo-random operand mixes on the defined codes
    lfsr = 32'hACE1_1357;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra   = lfsr * 32'd2654435761;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb   = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      applyAndCheck(n % 17, ra, rb, ra[9:5]);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule